// File: doc/BRIEF.md
# Three-Level Radix Page Table Walker

This block turns a 39-bit virtual address into a 56-bit physical address by walking a three-level radix page table held in memory. A request carries the virtual address, an access kind (read, write or execute) and a flag that says whether the access comes from user mode. The walker reads one 64-bit table entry per level over a valid/ready memory port. It starts from a root page number supplied on a configuration input. It stops at the first leaf entry, or it stops with a page fault.

The walker serves one translation at a time. It decodes each entry and recognises leaves and pointers. It applies the permission and privilege rules. It treats a clear accessed bit, or a clear dirty bit on a write, as a fault, so that software can set those bits. Leaves found above the last level map large pages. For those, the untranslated index bits of the virtual address pass straight into the physical address. The result stays on the response port until the requester takes it.

Top module: `pt_walker`

## Requirements
- R1: Virtual address fields are index 2 = bits 38:30, index 1 = bits 29:21, index 0 = bits 20:12, offset = bits 11:0. The walk reads index 2 first, then index 1, then index 0. Each read address is the table page number shifted left by 12 plus the index times 8. The first table page number is `root_ppn`, sampled when the request is accepted.
- R2: An entry with V (bit 0) set and R, W, X (bits 1, 2, 3) all clear, found at level 2 or 1, is a pointer. The walk continues at the next lower level, using the entry's page number (bits 53:10) as the next table. No further read is made after a leaf or a fault.
- R3: An entry with V set and any of R, W, X set is a leaf and ends the walk. On success, `rsp_fault`=0, `rsp_flags` = entry bits 7:0, and `rsp_paddr` = {leaf page number, offset}. For a leaf at level 1 the low 9 bits of that page number are taken from index 0. For a leaf at level 2 the low 18 bits are taken from indices 1 and 0.
- R4: An entry with V clear, or with W set and R clear, faults. Every fault returns `rsp_fault`=1 with `rsp_paddr`=0 and `rsp_flags`=0.
- R5: A pointer entry found at level 0 faults after exactly three reads.
- R6: Access code 0 (read) needs R, code 1 (write) needs W, code 2 (execute) needs X. Code 3 always faults. With `req_user`=1 the leaf must have U (bit 4) set. With `req_user`=0 it must have U clear. Otherwise the walk faults.
- R7: A leaf with A (bit 6) clear faults. A write to a leaf with D (bit 7) clear faults.
- R8: A leaf at level 2 whose page number has any of its low 18 bits set faults. A leaf at level 1 whose page number has any of its low 9 bits set faults.
- R9: `req_ready` is high only when no translation is in progress. A result holds `rsp_valid`, `rsp_fault`, `rsp_paddr` and `rsp_flags` unchanged until it is taken with `rsp_ready`. The walker is idle again in the next cycle.
- R10: In reset, `req_ready`=1, `mem_req_valid`=0 and `rsp_valid`=0.
- R11: While `mem_req_valid` is high and `mem_req_ready` is low, the read request and its address stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker can accept a request |
| req_vaddr | input | 39 | Virtual address to translate |
| req_access | input | 2 | 0 read, 1 write, 2 execute, 3 invalid |
| req_user | input | 1 | Access comes from user mode |
| root_ppn | input | 44 | Page number of the top-level table |
| mem_req_valid | output | 1 | Entry read request |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | 56 | Byte address of the entry |
| mem_rsp_valid | input | 1 | Entry data present |
| mem_rsp_ready | output | 1 | Walker takes entry data |
| mem_rsp_data | input | 64 | Table entry returned by memory |
| rsp_valid | output | 1 | Result present |
| rsp_ready | input | 1 | Requester takes the result |
| rsp_fault | output | 1 | Page fault |
| rsp_paddr | output | 56 | Translated physical address |
| rsp_flags | output | 8 | Leaf entry bits 7:0 |

## Verification
The first entry read is presented in the cycle after the request handshake. Each later read is presented in the cycle after the previous entry response is taken. The result appears in the cycle after the final entry response is taken, and `req_ready` returns in the cycle after `rsp_ready` is seen. The bench drives inputs and samples outputs on the falling edge. It waits for `rsp_valid` rather than counting a fixed latency, because memory readiness and response delay are randomised. It compares every read address, the read count and the held result against a reference walk written in the bench, including over stalls of random length on the response port.

// File: rtl/pt_walker_pkg.sv
package pt_walker_pkg;

    // Address geometry of the three-level radix table
    localparam int IDX_W        = 9;
    localparam int OFF_W        = 12;
    localparam int LEVELS       = 3;
    localparam int VA_W         = OFF_W + LEVELS * IDX_W;
    localparam int VPN_W        = VA_W - OFF_W;
    localparam int PPN_W        = 44;
    localparam int PA_W         = PPN_W + OFF_W;
    localparam int PTE_W        = 64;
    localparam int PTE_BYTES_LG = OFF_W - IDX_W;
    localparam int LVL_W        = $clog2(LEVELS);
    localparam int FLAGS_W      = 8;

    // Entry bit positions
    localparam int PTE_V       = 0;
    localparam int PTE_R       = 1;
    localparam int PTE_W_BIT   = 2;
    localparam int PTE_X       = 3;
    localparam int PTE_U       = 4;
    localparam int PTE_A       = 6;
    localparam int PTE_D       = 7;
    localparam int PTE_PPN_LSB = 10;

    typedef enum logic [1:0] {
        ACC_READ  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_EXEC  = 2'd2,
        ACC_BAD   = 2'd3
    } access_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FETCH = 2'd1,
        ST_WAIT  = 2'd2,
        ST_DONE  = 2'd3
    } walk_st_e;

    typedef struct packed {
        walk_st_e             st;
        logic [LVL_W-1:0]     lvl;
        logic [PPN_W-1:0]     tbl;
        logic [VA_W-1:0]      va;
        access_e              acc;
        logic                 user;
        logic                 fault;
        logic [PA_W-1:0]      pa;
        logic [FLAGS_W-1:0]   flags;
    } walk_state_t;

endpackage

// File: rtl/pt_walker_idx.sv
module pt_walker_idx
    import pt_walker_pkg::*;
(
    input  logic [PPN_W-1:0] tbl_ppn,
    input  logic [VPN_W-1:0] vpn,
    input  logic [LVL_W-1:0] level,
    output logic [PA_W-1:0]  entry_addr
);

    logic [IDX_W-1:0] idx_field [LEVELS];
    logic [IDX_W-1:0] idx_sel;

    for (genvar g = 0; g < LEVELS; g++) begin : g_field
        assign idx_field[g] = vpn[g*IDX_W +: IDX_W];
    end

    always_comb begin
        idx_sel = idx_field[0];
        for (int i = 0; i < LEVELS; i++) begin
            if (level == LVL_W'(i)) begin
                idx_sel = idx_field[i];
            end
        end
    end

    // Table base is page aligned, so base + idx*8 is a plain concatenation
    assign entry_addr = {tbl_ppn, idx_sel, {PTE_BYTES_LG{1'b0}}};

endmodule

// File: rtl/pt_walker_check.sv
module pt_walker_check
    import pt_walker_pkg::*;
(
    input  logic [PTE_W-1:0]   pte,
    input  logic [LVL_W-1:0]   level,
    input  logic [VA_W-1:0]    vaddr,
    input  access_e            access,
    input  logic               user,
    output logic               is_pointer,
    output logic               fault,
    output logic [PA_W-1:0]    paddr,
    output logic [FLAGS_W-1:0] flags,
    output logic [PPN_W-1:0]   next_ppn
);

    logic             v_b, r_b, w_b, x_b, u_b, a_b, d_b;
    logic             any_rwx, leaf, at_bottom;
    logic             perm_ok, priv_ok, dirty_ok, misaligned;
    logic             bad_enc, ptr_at_bottom, leaf_bad;
    logic [PPN_W-1:0] leaf_ppn, vpn_ext, sp_mask;
    logic [PPN_W-1:0] lvl_mask [LEVELS];
    logic             unused_pte_bits;

    assign v_b = pte[PTE_V];
    assign r_b = pte[PTE_R];
    assign w_b = pte[PTE_W_BIT];
    assign x_b = pte[PTE_X];
    assign u_b = pte[PTE_U];
    assign a_b = pte[PTE_A];
    assign d_b = pte[PTE_D];

    assign leaf_ppn = pte[PTE_PPN_LSB +: PPN_W];
    assign vpn_ext  = PPN_W'(vaddr[VA_W-1:OFF_W]);
    assign unused_pte_bits = ^{pte[PTE_W-1:PTE_PPN_LSB+PPN_W], pte[PTE_PPN_LSB-1:FLAGS_W]};

    // Page-number bits a leaf at each level leaves to the virtual address
    for (genvar g = 0; g < LEVELS; g++) begin : g_mask
        if (g == 0) begin : g_none
            assign lvl_mask[g] = '0;
        end else begin : g_low
            assign lvl_mask[g] = {PPN_W{1'b1}} >> (PPN_W - g*IDX_W);
        end
    end

    always_comb begin
        sp_mask = '0;
        for (int i = 0; i < LEVELS; i++) begin
            if (level == LVL_W'(i)) begin
                sp_mask = lvl_mask[i];
            end
        end
    end

    always_comb begin
        unique case (access)
            ACC_READ:  perm_ok = r_b;
            ACC_WRITE: perm_ok = w_b;
            ACC_EXEC:  perm_ok = x_b;
            default:   perm_ok = 1'b0;
        endcase
    end

    assign any_rwx       = r_b | w_b | x_b;
    assign leaf          = v_b & any_rwx;
    assign at_bottom     = (level == '0);
    assign priv_ok       = user ? u_b : ~u_b;
    assign dirty_ok      = (access != ACC_WRITE) | d_b;
    assign misaligned    = |(leaf_ppn & sp_mask);

    assign bad_enc       = ~v_b | (w_b & ~r_b);
    assign ptr_at_bottom = v_b & ~any_rwx & at_bottom;
    assign leaf_bad      = leaf & (~perm_ok | ~priv_ok | ~a_b | ~dirty_ok | misaligned);

    assign is_pointer    = v_b & ~any_rwx & ~at_bottom;
    assign fault         = bad_enc | ptr_at_bottom | leaf_bad;
    assign next_ppn      = leaf_ppn;

    assign paddr = fault ? '0
                         : {(leaf_ppn & ~sp_mask) | (vpn_ext & sp_mask), vaddr[OFF_W-1:0]};
    assign flags = fault ? '0 : pte[FLAGS_W-1:0];

endmodule

// File: rtl/pt_walker.sv
module pt_walker
    import pt_walker_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic [VA_W-1:0]    req_vaddr,
    input  logic [1:0]         req_access,
    input  logic               req_user,
    input  logic [PPN_W-1:0]   root_ppn,
    output logic               mem_req_valid,
    input  logic               mem_req_ready,
    output logic [PA_W-1:0]    mem_req_addr,
    input  logic               mem_rsp_valid,
    output logic               mem_rsp_ready,
    input  logic [PTE_W-1:0]   mem_rsp_data,
    output logic               rsp_valid,
    input  logic               rsp_ready,
    output logic               rsp_fault,
    output logic [PA_W-1:0]    rsp_paddr,
    output logic [FLAGS_W-1:0] rsp_flags
);

    walk_state_t        s_d, s_q;
    logic               chk_ptr, chk_fault;
    logic [PA_W-1:0]    chk_pa;
    logic [FLAGS_W-1:0] chk_flags;
    logic [PPN_W-1:0]   chk_next;

    pt_walker_idx u_idx (
        .tbl_ppn    (s_q.tbl),
        .vpn        (s_q.va[VA_W-1:OFF_W]),
        .level      (s_q.lvl),
        .entry_addr (mem_req_addr)
    );

    pt_walker_check u_chk (
        .pte        (mem_rsp_data),
        .level      (s_q.lvl),
        .vaddr      (s_q.va),
        .access     (s_q.acc),
        .user       (s_q.user),
        .is_pointer (chk_ptr),
        .fault      (chk_fault),
        .paddr      (chk_pa),
        .flags      (chk_flags),
        .next_ppn   (chk_next)
    );

    always_comb begin
        s_d = s_q;
        unique case (s_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    s_d.st    = ST_FETCH;
                    s_d.lvl   = LVL_W'(LEVELS - 1);
                    s_d.tbl   = root_ppn;
                    s_d.va    = req_vaddr;
                    s_d.acc   = access_e'(req_access);
                    s_d.user  = req_user;
                    s_d.fault = 1'b0;
                    s_d.pa    = '0;
                    s_d.flags = '0;
                end
            end
            ST_FETCH: begin
                if (mem_req_ready) begin
                    s_d.st = ST_WAIT;
                end
            end
            ST_WAIT: begin
                if (mem_rsp_valid) begin
                    if (chk_ptr) begin
                        s_d.st  = ST_FETCH;
                        s_d.tbl = chk_next;
                        s_d.lvl = s_q.lvl - 1'b1;
                    end else begin
                        s_d.st    = ST_DONE;
                        s_d.fault = chk_fault;
                        s_d.pa    = chk_pa;
                        s_d.flags = chk_flags;
                    end
                end
            end
            ST_DONE: begin
                if (rsp_ready) begin
                    s_d.st = ST_IDLE;
                end
            end
            default: s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign req_ready     = (s_q.st == ST_IDLE);
    assign mem_req_valid = (s_q.st == ST_FETCH);
    assign mem_rsp_ready = (s_q.st == ST_WAIT);
    assign rsp_valid     = (s_q.st == ST_DONE);
    assign rsp_fault     = s_q.fault;
    assign rsp_paddr     = s_q.pa;
    assign rsp_flags     = s_q.flags;

    AST_FIRST_READ_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=>
            (mem_req_addr[OFF_W-1:PTE_BYTES_LG] == $past(req_vaddr[VA_W-1 -: IDX_W]))
            && (mem_req_addr[PA_W-1:OFF_W] == $past(root_ppn)));                          // R1

    AST_BOTTOM_ENDS_WALK: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rsp_valid && mem_rsp_ready && (s_q.lvl == '0)) |=> (rsp_valid && !mem_req_valid)); // R5

    AST_FAULT_CLEARS_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault) |-> ((rsp_paddr == '0) && (rsp_flags == '0)));            // R4

    AST_WRITE_NEEDS_W_D: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_fault && (s_q.acc == ACC_WRITE)) |->
            (rsp_flags[PTE_W_BIT] && rsp_flags[PTE_D] && rsp_flags[PTE_A]));               // R7

    AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_ready) |=>
            (rsp_valid && $stable(rsp_fault) && $stable(rsp_paddr) && $stable(rsp_flags))); // R9

    AST_ONE_IN_FLIGHT: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (!rsp_valid && !mem_req_valid && !mem_rsp_ready));                  // R9

    AST_READ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));   // R11

endmodule

// File: tb/tb_pt_walker.sv
module tb_pt_walker;
    import pt_walker_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam longint unsigned ROOT = 64'h100;

    logic               clk = 1'b0;
    logic               rst_n;
    logic               req_valid;
    logic               req_ready;
    logic [VA_W-1:0]    req_vaddr;
    logic [1:0]         req_access;
    logic               req_user;
    logic [PPN_W-1:0]   root_ppn;
    logic               mem_req_valid;
    logic               mem_req_ready;
    logic [PA_W-1:0]    mem_req_addr;
    logic               mem_rsp_valid;
    logic               mem_rsp_ready;
    logic [PTE_W-1:0]   mem_rsp_data;
    logic               rsp_valid;
    logic               rsp_ready;
    logic               rsp_fault;
    logic [PA_W-1:0]    rsp_paddr;
    logic [FLAGS_W-1:0] rsp_flags;

    logic [63:0]     pmem [longint unsigned];
    longint unsigned exp_addr [3];
    int              nreads;
    int              checks = 0;
    int              errors = 0;
    bit              done = 1'b0;
    longint unsigned next_tbl = 64'h400;
    longint unsigned last_pa;
    bit              last_fault;

    pt_walker dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
        .req_access(req_access), .req_user(req_user), .root_ppn(root_ppn),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_ready(mem_rsp_ready), .mem_rsp_data(mem_rsp_data),
        .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_fault(rsp_fault),
        .rsp_paddr(rsp_paddr), .rsp_flags(rsp_flags)
    );

    initial forever #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input bit ok, input string req, input longint unsigned act,
                       input longint unsigned exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] pte_at(input longint unsigned a);
        if (pmem.exists(a)) return pmem[a];
        return 64'h0;
    endfunction

    function automatic logic [63:0] mk(input longint unsigned ppn, input logic [7:0] fl);
        return {10'b0, ppn[43:0], 2'b0, fl};
    endfunction

    function automatic logic [38:0] mkva(input int v2, input int v1, input int v0, input int off);
        return {v2[8:0], v1[8:0], v0[8:0], off[11:0]};
    endfunction

    task automatic put(input longint unsigned tbl, input int idx, input logic [63:0] p);
        pmem[(tbl << 12) + longint'(idx) * 8] = p;
    endtask

    // Reference walk written from the requirements
    task automatic ref_walk(input logic [38:0] va, input logic [1:0] acc, input bit user,
                            output bit f, output longint unsigned pa,
                            output logic [7:0] fl, output int reads);
        longint unsigned tbl;
        tbl = ROOT; f = 1'b0; pa = 0; fl = 8'h0; reads = 0;
        for (int lvl = 2; lvl >= 0; lvl--) begin
            longint unsigned idx, a, ppn, lowm;
            logic [63:0] p;
            bit ok;
            idx = (longint'(va) >> (12 + 9*lvl)) & 64'h1FF;
            a   = (tbl << 12) + idx * 8;
            exp_addr[reads] = a;
            reads++;
            p = pte_at(a);
            if (!p[0] || (p[2] && !p[1])) begin f = 1'b1; return; end
            if (!p[1] && !p[2] && !p[3]) begin
                if (lvl == 0) begin f = 1'b1; return; end
                tbl = p[53:10];
                continue;
            end
            ok = (acc == 2'd0 && p[1]) || (acc == 2'd1 && p[2]) || (acc == 2'd2 && p[3]);
            if (!ok || (user != p[4]) || !p[6] || (acc == 2'd1 && !p[7])) begin
                f = 1'b1; return;
            end
            ppn  = p[53:10];
            lowm = (64'd1 << (9*lvl)) - 1;
            if ((ppn & lowm) != 0) begin f = 1'b1; return; end
            pa = ((ppn | ((longint'(va) >> 12) & lowm)) << 12) | (longint'(va) & 64'hFFF);
            fl = p[7:0];
            return;
        end
    endtask

    task automatic build_path(input logic [38:0] va);
        longint unsigned tbl;
        tbl = ROOT;
        for (int lvl = 2; lvl >= 0; lvl--) begin
            longint unsigned a, ppn;
            logic [63:0] p;
            logic [7:0] fl;
            int k;
            a = (tbl << 12) + ((longint'(va) >> (12 + 9*lvl)) & 64'h1FF) * 8;
            if (!pmem.exists(a)) begin
                k = int'($urandom % 100);
                if ((lvl > 0 && k < 45) || (lvl == 0 && k < 4)) begin
                    p = mk(next_tbl, 8'h01);
                    next_tbl++;
                end else begin
                    fl    = 8'($urandom);
                    fl[0] = (k % 20) != 0;
                    fl[6] = (k % 7) != 0;
                    if (fl[3:1] == 3'b000) fl[1] = 1'b1;
                    ppn = {$urandom, $urandom};
                    ppn = ppn & 64'hFFF_FFFF_FFFF;
                    if (lvl > 0 && (k % 4) != 0) ppn = (ppn >> (9*lvl)) << (9*lvl);
                    p = mk(ppn, fl);
                end
                pmem[a] = p;
            end
            p = pmem[a];
            if (p[0] && p[3:1] == 3'b000 && lvl > 0) tbl = p[53:10];
            else break;
        end
    endtask

    // Memory model: random accept, random response delay
    initial begin
        bit req_hs, rsp_hs, pend, stall_prev;
        int dly, ix;
        longint unsigned hs_addr, prev_addr;
        req_hs = 0; rsp_hs = 0; pend = 0; stall_prev = 0; dly = 0;
        hs_addr = 0; prev_addr = 0;
        mem_req_ready = 1'b0; mem_rsp_valid = 1'b0; mem_rsp_data = '0;
        forever begin
            @(negedge clk);
            if (stall_prev)
                chk(mem_req_valid && (longint'(mem_req_addr) == prev_addr), "R11",
                    longint'(mem_req_addr), prev_addr);
            if (rsp_hs) mem_rsp_valid = 1'b0;
            if (req_hs) begin
                ix = (nreads < 3) ? nreads : 2;
                chk(nreads < 3 && hs_addr == exp_addr[ix], "R1", hs_addr, exp_addr[ix]);
                nreads++;
                pend = 1'b1;
                dly  = int'($urandom % 3);
            end
            if (pend && !mem_rsp_valid) begin
                if (dly == 0) begin
                    mem_rsp_valid = 1'b1;
                    mem_rsp_data  = pte_at(hs_addr);
                    pend = 1'b0;
                end else begin
                    dly--;
                end
            end
            mem_req_ready = ($urandom % 3) != 0;
            req_hs = mem_req_valid && mem_req_ready;
            if (req_hs) hs_addr = longint'(mem_req_addr);
            stall_prev = mem_req_valid && !mem_req_ready;
            prev_addr  = longint'(mem_req_addr);
            rsp_hs = mem_rsp_valid && mem_rsp_ready;
        end
    end

    task automatic run_one(input logic [38:0] va, input logic [1:0] acc, input bit user,
                           input string tag);
        bit ef;
        longint unsigned epa;
        logic [7:0] efl;
        int er, cnt, st;
        ref_walk(va, acc, user, ef, epa, efl, er);
        nreads = 0;
        @(negedge clk);
        req_vaddr = va; req_access = acc; req_user = user; req_valid = 1'b1;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        req_vaddr = 39'($urandom);
        req_access = 2'($urandom);
        cnt = 0;
        while (!rsp_valid && cnt < 1000) begin @(negedge clk); cnt++; end
        chk(rsp_valid, "R9", longint'(rsp_valid), 1);
        chk(rsp_fault == ef, tag, longint'(rsp_fault), longint'(ef));
        chk(longint'(rsp_paddr) == epa, tag, longint'(rsp_paddr), epa);
        chk(rsp_flags == efl, tag, longint'(rsp_flags), longint'(efl));
        chk(nreads == er, "R2", longint'(nreads), longint'(er));
        last_pa = longint'(rsp_paddr);
        last_fault = rsp_fault;
        st = int'($urandom % 3);
        repeat (st) begin
            @(negedge clk);
            chk(rsp_valid && longint'(rsp_paddr) == epa && rsp_fault == ef && !req_ready,
                "R9", longint'(rsp_paddr), epa);
        end
        rsp_ready = 1'b1;
        @(negedge clk);
        rsp_ready = 1'b0;
        chk(!rsp_valid && req_ready, "R9", longint'(rsp_valid), 0);
    endtask

    initial begin
        void'($urandom(32'h1F2E3D4C));
        rst_n = 1'b0; req_valid = 1'b0; req_vaddr = '0; req_access = '0; req_user = 1'b0;
        rsp_ready = 1'b0; root_ppn = PPN_W'(ROOT); nreads = 0;
        repeat (3) @(negedge clk);
        chk(req_ready && !mem_req_valid && !rsp_valid, "R10",
            {req_ready, mem_req_valid, rsp_valid}, 3'b100);
        rst_n = 1'b1;
        @(negedge clk);

        // Directed tables: T1 at 0x201, T2 at 0x202
        put(ROOT, 1, mk(64'h201, 8'h01));
        put(64'h201, 2, mk(64'h202, 8'h01));
        put(64'h202, 3, mk(64'h12345, 8'hC7));
        put(64'h202, 4, mk(64'h22, 8'h47));
        put(64'h202, 5, mk(64'h33, 8'h87));
        put(64'h202, 6, mk(64'h44, 8'hC5));
        put(64'h202, 7, mk(64'h55, 8'hCE));
        put(64'h202, 8, mk(64'h300, 8'h01));
        put(64'h202, 9, mk(64'h66, 8'hD3));
        put(64'h202, 10, mk(64'h77, 8'hC9));
        put(ROOT, 2, mk(64'h40000, 8'hC7));
        put(ROOT, 3, mk(64'h40001, 8'hC7));
        put(64'h201, 20, mk(64'h1200, 8'hC7));
        put(64'h201, 21, mk(64'h1201, 8'hC7));

        run_one(mkva(1, 2, 3, 12'hABC), 2'd0, 1'b0, "R3");
        chk(!last_fault && last_pa == 64'h12345ABC, "R3", last_pa, 64'h12345ABC);
        run_one(mkva(1, 2, 3, 12'h010), 2'd1, 1'b0, "R3");
        run_one(mkva(1, 2, 4, 12'h020), 2'd1, 1'b0, "R7");
        chk(last_fault, "R7", longint'(last_fault), 1);
        run_one(mkva(1, 2, 4, 12'h020), 2'd0, 1'b0, "R7");
        run_one(mkva(1, 2, 5, 12'h030), 2'd0, 1'b0, "R7");
        run_one(mkva(1, 2, 6, 12'h040), 2'd1, 1'b0, "R4");
        run_one(mkva(1, 2, 7, 12'h050), 2'd0, 1'b0, "R4");
        run_one(mkva(4, 0, 0, 12'h000), 2'd0, 1'b0, "R4");
        run_one(mkva(1, 2, 8, 12'h060), 2'd0, 1'b0, "R5");
        chk(last_fault && nreads == 3, "R5", longint'(nreads), 3);
        run_one(mkva(1, 2, 9, 12'h070), 2'd0, 1'b0, "R6");
        run_one(mkva(1, 2, 9, 12'h070), 2'd0, 1'b1, "R6");
        run_one(mkva(1, 2, 9, 12'h070), 2'd2, 1'b1, "R6");
        run_one(mkva(1, 2, 3, 12'h070), 2'd3, 1'b0, "R6");
        run_one(mkva(1, 2, 10, 12'h080), 2'd2, 1'b0, "R6");
        run_one(mkva(1, 2, 10, 12'h080), 2'd0, 1'b0, "R6");
        run_one(mkva(2, 5, 7, 12'h123), 2'd0, 1'b0, "R3");
        chk(!last_fault && last_pa == ((64'h40000 << 12) | (64'd5 << 21) | (64'd7 << 12) | 64'h123),
            "R3", last_pa, (64'h40000 << 12) | (64'd5 << 21) | (64'd7 << 12) | 64'h123);
        run_one(mkva(3, 5, 7, 12'h123), 2'd0, 1'b0, "R8");
        chk(last_fault, "R8", longint'(last_fault), 1);
        run_one(mkva(1, 20, 9, 12'h456), 2'd1, 1'b0, "R8");
        run_one(mkva(1, 21, 9, 12'h456), 2'd0, 1'b0, "R8");

        for (int n = 0; n < 300; n++) begin
            logic [38:0] va;
            va = 39'({$urandom, $urandom});
            va[38:30] = 9'(16 + ($urandom % 496));
            build_path(va);
            run_one(va, 2'($urandom), 1'($urandom), "R3");
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL R9 watchdog actual=hung expected=complete");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule